// File: doc/BRIEF.md
# Multi-Format Serial Audio Receiver

This block turns three serial audio data lines into parallel stereo samples. The three lines share one bit clock and one frame clock. The frame clock splits every frame into a left half and a right half. Each half-frame yields one 24-bit two's-complement word for each line, and narrower words are sign-extended to 24 bits. The bit clock also serves as the block's clock. Inputs are sampled on its rising edge.

A 3-bit format code selects one of five framings, listed under Requirements. The framings differ in the frame clock level that marks the left channel, in where the word sits within its half-frame, and in word length. The code is meant to stay constant while the block runs, and the block is reset whenever the code changes. Once a frame's left and right words are both complete, all six outputs update in the same cycle and a one-cycle strobe marks the new frame.

Top module: `serial_audio_rx`

## Requirements
- R1: While `rst_n` is low and after its release, every sample output reads zero and `frame_valid` is low until the first complete frame has been received.
- R2: Format code 0 takes the last 16 bits before a frame clock change as the word and sign-extends bit 15. Bits earlier in the half-frame are ignored, and 16 bit clocks per half-frame are enough.
- R3: Format code 1 takes the last 20 bits before a frame clock change and sign-extends bit 19. Earlier bits are ignored.
- R4: Format code 4 takes the last 24 bits before a frame clock change as the full word. Earlier bits are ignored.
- R5: In format code 2, the word's MSB is the bit sampled on the first rising edge that sees the new frame clock level. The next 23 bits follow MSB first and later bits are ignored. If the half-frame is shorter than 24 bits, the missing low bits read zero.
- R6: In format code 3, the MSB is sampled on the second rising edge after the frame clock change. Frame clock low marks the left channel. With 16 bit clocks per half-frame, the top 16 bits arrive and the low 8 bits read zero.
- R7: In format codes 0, 1, 2 and 4, frame clock high marks the left channel and low marks the right channel. Left words appear on `left_out` and right words on `right_out`, with line k in bits [24k+23:24k].
- R8: `frame_valid` pulses for exactly one cycle after each frame's right word is complete. It is never high in two consecutive cycles, and the outputs change only in the cycle it is high.
- R9: Format codes 5, 6 and 7 capture nothing. `frame_valid` stays low and the outputs keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bclk | input | 1 | Bit clock; also the block clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| lrclk | input | 1 | Frame clock; its level selects the channel |
| sdata | input | 3 | Serial data, one bit per line, MSB first |
| fmt | input | 3 | Framing code 0..4; 5..7 unused |
| left_out | output | 72 | Left words, line k at bits [24k+23:24k] |
| right_out | output | 72 | Right words, line k at bits [24k+23:24k] |
| frame_valid | output | 1 | One-cycle strobe when a new frame is on the outputs |

## Verification
A wrong boundary or bit count inside the block shows up on the outputs as words shifted by one or more bit positions. Depending on the format, it can also appear as lost sign bits or lost low bits. The error is visible at the first strobe after the fault, which comes within about one frame. A wrong channel polarity swaps the left and right words at that same strobe. A stale staging flag shows up as a missing strobe, or as two strobes within one frame. Both show at the very next frame.

// File: rtl/sar_pkg.sv
// Shared definitions for the serial audio receiver.
// Assumes the framing code is 3 bits wide and codes above 4 are unused.
package sar_pkg;
    typedef enum logic [2:0] {
        FMT_TAIL16 = 3'd0,
        FMT_TAIL20 = 3'd1,
        FMT_HEAD24 = 3'd2,
        FMT_I2S    = 3'd3,
        FMT_TAIL24 = 3'd4
    } sar_fmt_e;

    localparam int SAR_SHORT_A = 16;
    localparam int SAR_SHORT_B = 20;

    // Returns 1 for any framing code the receiver understands.
    function automatic logic sar_fmt_known(input logic [2:0] f);
        return f <= 3'd4;
    endfunction
endpackage

// File: rtl/sar_frame_track.sv
// Tracks the frame clock. It emits a boundary pulse where a new word
// starts, a bit index counted from that boundary, and the channel of the
// half-frame that just ended.
// Assumes each half-frame lasts at least two bit clocks.
module sar_frame_track
    import sar_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lrclk,
    input  logic [2:0]       fmt,
    output logic             boundary,
    output logic             cap,
    output logic             ended_left,
    output logic [IDX_W-1:0] idx
);
    localparam logic [IDX_W-1:0] CNT_MAX = {IDX_W{1'b1}};

    logic             seen;
    logic             lr_q;
    logic             chg_q;
    logic [IDX_W-1:0] cnt;
    logic             chg;
    logic             left_lvl;

    assign chg = seen && (lrclk != lr_q);

    // Remember the previous frame clock level and the delayed change flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen  <= 1'b0;
            lr_q  <= 1'b0;
            chg_q <= 1'b0;
        end else begin
            seen  <= 1'b1;
            lr_q  <= lrclk;
            chg_q <= chg;
        end
    end

    // Place the word boundary: one edge later for the delayed-MSB format
    always_comb begin
        boundary   = (fmt == FMT_I2S) ? chg_q : chg;
        cap        = boundary && sar_fmt_known(fmt);
        left_lvl   = (fmt == FMT_I2S) ? 1'b0 : 1'b1;
        ended_left = (~lrclk) == left_lvl;
        idx        = boundary ? '0 : cnt;
    end

    // Count bit clocks since the boundary, saturating at the top value
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= CNT_MAX;
        end else if (boundary) begin
            cnt <= IDX_W'(1);
        end else if (cnt != CNT_MAX) begin
            cnt <= cnt + IDX_W'(1);
        end
    end

    // R5
    idx_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (idx == IDX_W'(1) || boundary));
endmodule

// File: rtl/sar_lane.sv
// Deserialises one data line. A free-running shift register serves the
// tail-aligned formats. A boundary-anchored accumulator serves the
// head-aligned formats. The word is selected by framing code.
// Assumes the word width is at least 20 bits.
module sar_lane
    import sar_pkg::*;
#(
    parameter int W     = 24,
    parameter int IDX_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sd,
    input  logic [2:0]       fmt,
    input  logic             boundary,
    input  logic [IDX_W-1:0] idx,
    output logic [W-1:0]     word
);
    logic [W-1:0] sh;
    logic [W-1:0] acc;
    logic [W-1:0] slot_hot;

    // Keep the last W received bits for the tail-aligned formats
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[W-2:0], sd};
    end

    // One-hot slot for the current bit, empty once W bits are placed
    always_comb begin
        if (idx < IDX_W'(W)) slot_hot = W'(1) << (W - 1 - int'(idx));
        else                 slot_hot = '0;
    end

    // Fill the word MSB first from the boundary; unfilled bits stay zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
        end else if (boundary) begin
            acc <= {sd, {(W-1){1'b0}}};
        end else begin
            acc <= (acc & ~slot_hot) | (sd ? slot_hot : '0);
        end
    end

    // Choose and sign-extend the word that matches the framing code
    always_comb begin
        case (fmt)
            FMT_TAIL16: word = {{(W-SAR_SHORT_A){sh[SAR_SHORT_A-1]}}, sh[SAR_SHORT_A-1:0]};
            FMT_TAIL20: word = {{(W-SAR_SHORT_B){sh[SAR_SHORT_B-1]}}, sh[SAR_SHORT_B-1:0]};
            FMT_TAIL24: word = sh;
            default:    word = acc;
        endcase
    end

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boundary |=> (acc[W-2:0] == '0 || boundary));
endmodule

// File: rtl/serial_audio_rx.sv
// Top level of the multi-format serial audio receiver. It holds each
// frame's left words until the right words are complete, then updates
// all outputs together with a one-cycle strobe.
// Assumes the bit clock drives clk and that a reset follows any change
// of the framing code.
module serial_audio_rx
    import sar_pkg::*;
#(
    parameter int LINES = 3,
    parameter int W     = 24
) (
    input  logic               bclk,
    input  logic               rst_n,
    input  logic               lrclk,
    input  logic [LINES-1:0]   sdata,
    input  logic [2:0]         fmt,
    output logic [LINES*W-1:0] left_out,
    output logic [LINES*W-1:0] right_out,
    output logic               frame_valid
);
    localparam int IDX_W = $clog2(W + 1);

    logic               boundary;
    logic               cap;
    logic               ended_left;
    logic [IDX_W-1:0]   idx;
    logic [LINES*W-1:0] word_all;
    logic [LINES*W-1:0] left_stage;
    logic               left_ok;

    sar_frame_track #(.IDX_W(IDX_W)) i_track (
        .clk        (bclk),
        .rst_n      (rst_n),
        .lrclk      (lrclk),
        .fmt        (fmt),
        .boundary   (boundary),
        .cap        (cap),
        .ended_left (ended_left),
        .idx        (idx)
    );

    for (genvar k = 0; k < LINES; k++) begin : g_lane
        sar_lane #(.W(W), .IDX_W(IDX_W)) i_lane (
            .clk      (bclk),
            .rst_n    (rst_n),
            .sd       (sdata[k]),
            .fmt      (fmt),
            .boundary (boundary),
            .idx      (idx),
            .word     (word_all[k*W +: W])
        );
    end

    // Stage left words, then publish the whole frame when right completes
    always_ff @(posedge bclk) begin
        if (!rst_n) begin
            left_stage  <= '0;
            left_ok     <= 1'b0;
            left_out    <= '0;
            right_out   <= '0;
            frame_valid <= 1'b0;
        end else begin
            frame_valid <= 1'b0;
            if (cap) begin
                if (ended_left) begin
                    left_stage <= word_all;
                    left_ok    <= 1'b1;
                end else begin
                    if (left_ok) begin
                        left_out    <= left_stage;
                        right_out   <= word_all;
                        frame_valid <= 1'b1;
                    end
                    left_ok <= 1'b0;
                end
            end
        end
    end

    // R8
    single_pulse_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);

    // R8
    hold_between_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        !frame_valid |-> ($stable(left_out) && $stable(right_out)));

    // R9
    unused_fmt_chk: assert property (@(posedge bclk) disable iff (!rst_n)
        (fmt > 3'd4) |=> !frame_valid);
endmodule

// File: tb/test_serial_audio_rx.sv
module test_serial_audio_rx;
    localparam int LINES = 3;
    localparam int W     = 24;
    localparam int VW    = LINES * W;

    logic             bclk  = 1'b0;
    logic             rst_n = 1'b0;
    logic             lrclk = 1'b0;
    logic [LINES-1:0] sdata = '0;
    logic [2:0]       fmt   = 3'd0;
    logic [VW-1:0]    left_out;
    logic [VW-1:0]    right_out;
    logic             frame_valid;

    int    checks = 0;
    int    errors = 0;
    int    got_frames = 0;
    logic  prev_v = 1'b0;
    string cur_tag = "R1";
    logic [VW-1:0] q_l[$];
    logic [VW-1:0] q_r[$];

    always #2 bclk = ~bclk;

    serial_audio_rx #(.LINES(LINES), .W(W)) i_serial_audio_rx (
        .bclk(bclk), .rst_n(rst_n), .lrclk(lrclk), .sdata(sdata), .fmt(fmt),
        .left_out(left_out), .right_out(right_out), .frame_valid(frame_valid)
    );

    task automatic check(input bit ok, input string tag, input logic [VW-1:0] act,
                         input logic [VW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rand_word();
        return W'($urandom);
    endfunction

    // Bit on the line in slot s of a half-frame carrying cur (prev = word before)
    function automatic logic slot_bit(input int f, input int bph, input int s,
                                      input logic [W-1:0] cur, input logic [W-1:0] prev);
        int len;
        int pos;
        if (f == 3) begin
            if (s == 0) begin
                pos = W - bph;
                return (pos >= 0) ? prev[pos] : 1'($urandom);
            end
            return (s <= W) ? cur[W-s] : 1'($urandom);
        end
        if (f == 2) return (s < W) ? cur[W-1-s] : 1'($urandom);
        if (f == 0 || f == 1 || f == 4) begin
            len = (f == 0) ? 16 : (f == 1) ? 20 : 24;
            pos = bph - 1 - s;
            return (pos < len) ? cur[pos] : 1'($urandom);
        end
        return 1'($urandom);
    endfunction

    // Expected output word from the requirements
    function automatic logic [W-1:0] exp_word(input int f, input int bph, input logic [W-1:0] w);
        logic [W-1:0] m;
        case (f)
            0: return {{(W-16){w[15]}}, w[15:0]};
            1: return {{(W-20){w[19]}}, w[19:0]};
            4: return w;
            default: begin
                m = '1;
                if (bph < W) m = m << (W - bph);
                return w & m;
            end
        endcase
    endfunction

    function automatic logic [VW-1:0] exp_vec(input int f, input int bph, input logic [VW-1:0] v);
        logic [VW-1:0] r;
        for (int k = 0; k < LINES; k++) r[k*W +: W] = exp_word(f, bph, v[k*W +: W]);
        return r;
    endfunction

    task automatic send_half(input logic lvl, input int f, input int bph,
                             input logic [VW-1:0] cur, input logic [VW-1:0] prev);
        for (int s = 0; s < bph; s++) begin
            logic [LINES-1:0] b;
            for (int k = 0; k < LINES; k++)
                b[k] = slot_bit(f, bph, s, cur[k*W +: W], prev[k*W +: W]);
            @(negedge bclk);
            lrclk = lvl;
            sdata = b;
        end
    endtask

    task automatic run_burst(input int f, input int bph, input int nfr, input string tag);
        logic          left_lvl;
        logic [VW-1:0] lw;
        logic [VW-1:0] rw;
        logic [VW-1:0] prev;
        int            got0;
        int            expn;
        left_lvl = (f == 3) ? 1'b0 : 1'b1;
        cur_tag  = tag;
        @(negedge bclk);
        rst_n = 1'b0; fmt = 3'(f); lrclk = ~left_lvl; sdata = '0;
        repeat (2) @(negedge bclk);
        rst_n = 1'b1;
        got0 = got_frames;
        prev = '0;
        for (int k = 0; k < LINES; k++) rw[k*W +: W] = rand_word();
        send_half(~left_lvl, f, bph, rw, prev);
        prev = rw;
        for (int fr = 0; fr < nfr; fr++) begin
            if (fr == 0) begin
                lw = {24'h7FFFFF, 24'h008000, 24'hFFFFFF};
                rw = {24'h000000, 24'h080000, 24'h800000};
            end else begin
                for (int k = 0; k < LINES; k++) begin
                    lw[k*W +: W] = rand_word();
                    rw[k*W +: W] = rand_word();
                end
            end
            if (f <= 4) begin
                q_l.push_back(exp_vec(f, bph, lw));
                q_r.push_back(exp_vec(f, bph, rw));
            end
            send_half(left_lvl, f, bph, lw, prev);
            send_half(~left_lvl, f, bph, rw, lw);
            prev = rw;
        end
        for (int k = 0; k < LINES; k++) lw[k*W +: W] = rand_word();
        send_half(left_lvl, f, bph, lw, prev);
        repeat (4) @(negedge bclk);
        expn = (f <= 4) ? nfr : 0;
        check(got_frames - got0 == expn, {tag, " R8 frame count"},
              VW'(got_frames - got0), VW'(expn));
        check(q_l.size() == 0, {tag, " R8 frames left undelivered"}, VW'(q_l.size()), '0);
        q_l.delete();
        q_r.delete();
    endtask

    // Compare each strobed frame with the oldest expected frame
    always @(negedge bclk) begin
        if (rst_n && frame_valid) begin
            got_frames++;
            check(!prev_v, {cur_tag, " R8 strobe longer than one cycle"}, VW'(1), '0);
            if (q_l.size() == 0) begin
                check(1'b0, {cur_tag, " R9 R8 unexpected strobe"}, VW'(1), '0);
            end else begin
                check(left_out == q_l[0], {cur_tag, " left"}, left_out, q_l[0]);
                check(right_out == q_r[0], {cur_tag, " right"}, right_out, q_r[0]);
                void'(q_l.pop_front());
                void'(q_r.pop_front());
            end
        end
        prev_v = frame_valid;
    end

    initial begin
        repeat (200000) @(posedge bclk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] hold_l;
        logic [VW-1:0] hold_r;
        void'($urandom(32'd4711));
        repeat (3) @(negedge bclk);
        // R1: reset state
        check(left_out == '0, "R1 left after reset", left_out, '0);
        check(right_out == '0, "R1 right after reset", right_out, '0);
        check(frame_valid == 1'b0, "R1 strobe during reset", VW'(frame_valid), '0);
        rst_n = 1'b1;
        lrclk = 1'b0;
        repeat (5) @(negedge bclk);
        check(frame_valid == 1'b0 && left_out == '0, "R1 idle after reset", left_out, '0);

        run_burst(0, 16, 6, "R2 R7 tail16 32fs");
        run_burst(0, 32, 6, "R2 R7 tail16 junk-lead");
        run_burst(1, 20, 5, "R3 R7 tail20 40fs");
        run_burst(1, 32, 5, "R3 R7 tail20 64fs");
        run_burst(4, 24, 5, "R4 R7 tail24 48fs");
        run_burst(4, 32, 5, "R4 R7 tail24 64fs");
        run_burst(2, 32, 5, "R5 R7 head24 64fs");
        run_burst(2, 24, 4, "R5 R7 head24 48fs");
        run_burst(2, 20, 4, "R5 head24 short half");
        run_burst(3, 16, 6, "R6 i2s 32fs");
        run_burst(3, 32, 6, "R6 i2s 64fs");

        // R9: unused codes leave outputs untouched
        run_burst(1, 32, 2, "R9 prime");
        hold_l = left_out;
        hold_r = right_out;
        fmt = 3'd5;
        cur_tag = "R9 code5";
        for (int i = 0; i < 3; i++) send_half(1'(i % 2), 5, 32, '0, '0);
        check(left_out == hold_l, "R9 left held on code 5", left_out, hold_l);
        check(right_out == hold_r, "R9 right held on code 5", right_out, hold_r);
        run_burst(7, 32, 3, "R9 code7");
        run_burst(6, 24, 3, "R9 code6");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule